// File: doc/BRIEF.md
# Wall-Clock Pulse Timer

This block keeps a time base made of two counters. A tick counter counts reference-clock strobes inside the current pulse period. A pulse counter counts completed periods. A period lasts a whole number of seconds, so it holds `SECS_PER_PULSE * TICKS_PER_SEC` ticks. Both values are elaboration parameters. The reference clock reaches the block as a one-cycle strobe on `tick_i` in the `clk_i` domain.

Software uses a small word-addressed register file on a single-cycle bus. Through it, software can:
- read both counters, a snapshot copy of the tick count and two base-time words;
- write the control register, the pulse count, the tick count and the base-time words.

The base-time words hold a seconds value counted from the GPS epoch (Unix time minus 315964800) and a nanoseconds part. Software fills them in. The block does not interpret them.

Top module: `wall_pulse_timer`

## Requirements
- R1: After reset, every register reads 0 and counting is disabled. Before any request, `ack_o` and `err_o` are low.
- R2: The register offsets are: control 0x00 (bit 0 = enable), pulse count 0x04, snapshot tick count 0x08, tick count 0x0C, base-time seconds 0x24, base-time nanoseconds 0x28. Every request gets `ack_o` for one cycle, in the cycle after the request. A read returns the register value as it stood in the request cycle.
- R3: A control write that sets enable while enable is 0 clears the pulse count, the tick count and the snapshot to 0. Writing enable=1 while already enabled clears nothing.
- R4: While enabled, each `tick_i` strobe adds one to the tick count. A strobe that finds the tick count at or above period−1 sets it to 0 and adds one to the pulse count. This includes a loaded value beyond the period.
- R5: While enable is 0, `tick_i` has no effect, and the counters keep their values.
- R6: A write to the tick-count register loads the value, truncated to the tick counter width, into both the tick count and the snapshot.
- R7: After every counter step or wrap, the snapshot equals the new tick count.
- R8: A write to the snapshot register returns `err_o` with `ack_o` and leaves the snapshot unchanged.
- R9: A read or write at any other offset, misaligned offsets included, returns `err_o` with `ack_o`, read data 0, and changes no register.
- R10: The control, pulse-count and both base-time registers store all written bits and read them back unchanged.
- R11: A write to the tick or pulse register in the same cycle as a `tick_i` strobe takes priority. The strobe is dropped for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle reference tick strobe |
| req_i | input | 1 | Bus request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid with `ack_o` |
| ack_o | output | 1 | Response strobe, one cycle after `req_i` |
| err_o | output | 1 | Error response, raised together with `ack_o` |

## Verification
The bench builds the block with `SECS_PER_PULSE=3` and `TICKS_PER_SEC=4`. That gives a 12-tick period and a 4-bit tick counter. Several pulse wraps therefore take only a few dozen strobes. Loading a value of 13 drives the wrap-from-beyond-period path without truncation. The width stays small enough that the bench can compute every expected counter value directly.

// File: rtl/wpt_pkg.sv
package wpt_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL,
    SEL_PULSE,
    SEL_SNAP,
    SEL_TICK,
    SEL_BASE_S,
    SEL_BASE_NS,
    SEL_NONE
  } reg_sel_e;

  localparam logic [7:0] OFF_CTRL    = 8'h00;
  localparam logic [7:0] OFF_PULSE   = 8'h04;
  localparam logic [7:0] OFF_SNAP    = 8'h08;
  localparam logic [7:0] OFF_TICK    = 8'h0C;
  localparam logic [7:0] OFF_BASE_S  = 8'h24;
  localparam logic [7:0] OFF_BASE_NS = 8'h28;
endpackage

// File: rtl/wpt_decode.sv
module wpt_decode
  import wpt_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    if      (addr_i == ADDR_W'(OFF_CTRL))    sel_o = SEL_CTRL;
    else if (addr_i == ADDR_W'(OFF_PULSE))   sel_o = SEL_PULSE;
    else if (addr_i == ADDR_W'(OFF_SNAP))    sel_o = SEL_SNAP;
    else if (addr_i == ADDR_W'(OFF_TICK))    sel_o = SEL_TICK;
    else if (addr_i == ADDR_W'(OFF_BASE_S))  sel_o = SEL_BASE_S;
    else if (addr_i == ADDR_W'(OFF_BASE_NS)) sel_o = SEL_BASE_NS;
    else                                     sel_o = SEL_NONE;
  end
endmodule

// File: rtl/wpt_counter.sv
module wpt_counter #(
  parameter int PERIOD = 12,
  parameter int TICK_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic              load_tick_i,
  input  logic              load_pulse_i,
  input  logic [TICK_W-1:0] tick_wdata_i,
  input  logic [DATA_W-1:0] pulse_wdata_i,
  output logic [TICK_W-1:0] tick_o,
  output logic [TICK_W-1:0] snap_o,
  output logic [DATA_W-1:0] pulse_o
);
  localparam logic [TICK_W-1:0] LAST = TICK_W'(PERIOD - 1);

  logic [TICK_W-1:0] tick_q, snap_q, tick_nxt;
  logic [DATA_W-1:0] pulse_q;
  logic              wrap;

  // >= so an out-of-range loaded value still rolls over on the next step
  assign wrap     = (tick_q >= LAST);
  assign tick_nxt = wrap ? '0 : tick_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q  <= '0;
      snap_q  <= '0;
      pulse_q <= '0;
    end else if (clear_i) begin
      tick_q  <= '0;
      snap_q  <= '0;
      pulse_q <= '0;
    end else if (load_tick_i) begin
      tick_q  <= tick_wdata_i;
      snap_q  <= tick_wdata_i;
    end else if (load_pulse_i) begin
      pulse_q <= pulse_wdata_i;
    end else if (step_i) begin
      tick_q  <= tick_nxt;
      snap_q  <= tick_nxt;
      if (wrap) pulse_q <= pulse_q + 1'b1;
    end
  end

  assign tick_o  = tick_q;
  assign snap_o  = snap_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/wpt_regs.sv
module wpt_regs
  import wpt_pkg::*;
#(
  parameter int TICK_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  reg_sel_e          sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [TICK_W-1:0] tick_i_cnt,
  input  logic [TICK_W-1:0] snap_i_cnt,
  input  logic [DATA_W-1:0] pulse_i_cnt,
  output logic              enable_o,
  output logic              clear_o,
  output logic              step_o,
  output logic              load_tick_o,
  output logic              load_pulse_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ack_o,
  output logic              err_o
);
  logic [DATA_W-1:0] ctrl_q, base_s_q, base_ns_q, rd_mux, rdata_q;
  logic              ack_q, err_q, wr, bad;

  assign wr  = req_i && we_i;
  assign bad = (sel_i == SEL_NONE) || (wr && sel_i == SEL_SNAP);

  assign enable_o     = ctrl_q[0];
  assign clear_o      = wr && !bad && sel_i == SEL_CTRL && wdata_i[0] && !ctrl_q[0];
  assign load_tick_o  = wr && sel_i == SEL_TICK;
  assign load_pulse_o = wr && sel_i == SEL_PULSE;
  assign step_o       = ctrl_q[0] && tick_i && !load_tick_o && !load_pulse_o;

  always_comb begin
    unique case (sel_i)
      SEL_CTRL:    rd_mux = ctrl_q;
      SEL_PULSE:   rd_mux = pulse_i_cnt;
      SEL_SNAP:    rd_mux = DATA_W'(snap_i_cnt);
      SEL_TICK:    rd_mux = DATA_W'(tick_i_cnt);
      SEL_BASE_S:  rd_mux = base_s_q;
      SEL_BASE_NS: rd_mux = base_ns_q;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      base_s_q  <= '0;
      base_ns_q <= '0;
    end else if (wr) begin
      if (sel_i == SEL_CTRL)    ctrl_q    <= wdata_i;
      if (sel_i == SEL_BASE_S)  base_s_q  <= wdata_i;
      if (sel_i == SEL_BASE_NS) base_ns_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= req_i;
      err_q   <= req_i && bad;
      rdata_q <= (req_i && !we_i && !bad) ? rd_mux : '0;
    end
  end

  assign rdata_o = rdata_q;
  assign ack_o   = ack_q;
  assign err_o   = err_q;
endmodule

// File: rtl/wall_pulse_timer.sv
module wall_pulse_timer
  import wpt_pkg::*;
#(
  parameter int SECS_PER_PULSE = 1,
  parameter int TICKS_PER_SEC  = 19_200_000,
  parameter int ADDR_W         = 6,
  parameter int DATA_W         = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ack_o,
  output logic              err_o
);
  localparam int PERIOD = SECS_PER_PULSE * TICKS_PER_SEC;
  localparam int TICK_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  reg_sel_e          sel;
  logic              enable, clear, step, load_tick, load_pulse;
  logic [TICK_W-1:0] tick_cnt, snap_cnt;
  logic [DATA_W-1:0] pulse_cnt;

  wpt_decode #(.ADDR_W(ADDR_W)) i_decode (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  wpt_regs #(.TICK_W(TICK_W), .DATA_W(DATA_W)) i_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .req_i        (req_i),
    .we_i         (we_i),
    .sel_i        (sel),
    .wdata_i      (wdata_i),
    .tick_i_cnt   (tick_cnt),
    .snap_i_cnt   (snap_cnt),
    .pulse_i_cnt  (pulse_cnt),
    .enable_o     (enable),
    .clear_o      (clear),
    .step_o       (step),
    .load_tick_o  (load_tick),
    .load_pulse_o (load_pulse),
    .rdata_o      (rdata_o),
    .ack_o        (ack_o),
    .err_o        (err_o)
  );

  wpt_counter #(.PERIOD(PERIOD), .TICK_W(TICK_W), .DATA_W(DATA_W)) i_counter (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clear_i       (clear),
    .step_i        (step),
    .load_tick_i   (load_tick),
    .load_pulse_i  (load_pulse),
    .tick_wdata_i  (wdata_i[TICK_W-1:0]),
    .pulse_wdata_i (wdata_i),
    .tick_o        (tick_cnt),
    .snap_o        (snap_cnt),
    .pulse_o       (pulse_cnt)
  );
endmodule

// File: rtl/wall_pulse_timer_chk.sv
module wall_pulse_timer_chk #(
  parameter int PERIOD = 12,
  parameter int TICK_W = 4,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              ack_o,
  input logic              err_o,
  input logic              enable,
  input logic [TICK_W-1:0] tick_cnt,
  input logic [TICK_W-1:0] snap_cnt,
  input logic [DATA_W-1:0] pulse_cnt
);
  localparam logic [TICK_W-1:0] LAST = TICK_W'(PERIOD - 1);
  logic wr;
  assign wr = req_i && we_i;

  assert_ack_follows_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ack_o);

  assert_err_with_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ack_o);

  assert_enable_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADDR_W'(8'h00) && wdata_i[0] && !enable)
    |=> (tick_cnt == '0 && snap_cnt == '0 && pulse_cnt == '0 && enable));

  assert_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable && tick_i && !wr && tick_cnt == LAST)
    |=> (tick_cnt == '0 && pulse_cnt == $past(pulse_cnt) + 1'b1));

  assert_hold_disabled_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable && !wr) |=> ($stable(tick_cnt) && $stable(pulse_cnt)));

  assert_tick_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADDR_W'(8'h0C))
    |=> (tick_cnt == $past(wdata_i[TICK_W-1:0]) && snap_cnt == tick_cnt));

  assert_snap_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable && tick_i && !wr) |=> (snap_cnt == tick_cnt));

  assert_snap_write_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADDR_W'(8'h08)) |=> (err_o && ack_o));
endmodule

bind wall_pulse_timer wall_pulse_timer_chk #(
  .PERIOD (PERIOD),
  .TICK_W (TICK_W),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .ack_o     (ack_o),
  .err_o     (err_o),
  .enable    (enable),
  .tick_cnt  (tick_cnt),
  .snap_cnt  (snap_cnt),
  .pulse_cnt (pulse_cnt)
);

// File: tb/test_wall_pulse_timer.sv
module test_wall_pulse_timer;
  localparam int SECS   = 3;
  localparam int TPS    = 4;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CTRL = 6'h00, A_PULSE = 6'h04, A_SNAP = 6'h08,
                                A_TICK = 6'h0C, A_BS = 6'h24, A_BNS = 6'h28;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0;
  logic              req = 1'b0;
  logic              we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              ack, err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wall_pulse_timer #(
    .SECS_PER_PULSE (SECS),
    .TICKS_PER_SEC  (TPS),
    .ADDR_W         (ADDR_W),
    .DATA_W         (DATA_W)
  ) i_wall_pulse_timer (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .tick_i  (tick),
    .req_i   (req),
    .we_i    (we),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .ack_o   (ack),
    .err_o   (err)
  );

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // one bus access; response sampled at the negedge after the capturing posedge
  task automatic access(input bit w, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                        input bit t, output logic [31:0] rd, output bit ak, output bit er);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; tick = t;
    @(negedge clk);
    req = 1'b0; we = 1'b0; tick = 1'b0;
    rd = rdata; ak = ack; er = err;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input string rq);
    logic [31:0] rd; bit ak, er;
    access(1'b1, a, d, 1'b0, rd, ak, er);
    check(ak && !er, rq, {30'd0, ak, er}, 32'h2);
  endtask

  task automatic rd_exp(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string rq);
    logic [31:0] rd; bit ak, er;
    access(1'b0, a, '0, 1'b0, rd, ak, er);
    check(ak && !er && rd == exp, rq, rd, exp);
  endtask

  task automatic err_exp(input bit w, input logic [ADDR_W-1:0] a, input string rq);
    logic [31:0] rd; bit ak, er;
    access(w, a, 32'hDEAD_BEEF, 1'b0, rd, ak, er);
    check(ak && er && rd == 0, rq, {rd[29:0], ak, er}, 32'h3);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic t_reset();
    check(ack == 1'b0 && err == 1'b0, "R1 idle response", {30'd0, ack, err}, 0);
    rd_exp(A_CTRL, 0, "R1 ctrl");
    rd_exp(A_PULSE, 0, "R1 pulse");
    rd_exp(A_SNAP, 0, "R1 snap");
    rd_exp(A_TICK, 0, "R1 tick");
    rd_exp(A_BS, 0, "R1 base s");
    rd_exp(A_BNS, 0, "R1 base ns");
  endtask

  task automatic t_storage();
    wr(A_BS, 32'h1234_5678, "R10 wr base s");
    wr(A_BNS, 32'd999_999_999, "R10 wr base ns");
    wr(A_CTRL, 32'h0000_00A0, "R10 wr ctrl");
    wr(A_PULSE, 32'd7, "R10 wr pulse");
    rd_exp(A_BS, 32'h1234_5678, "R10 base s");
    rd_exp(A_BNS, 32'd999_999_999, "R10 base ns");
    rd_exp(A_CTRL, 32'h0000_00A0, "R10 ctrl");
    rd_exp(A_PULSE, 32'd7, "R10 pulse");
  endtask

  task automatic t_disabled();
    ticks(5);
    rd_exp(A_TICK, 0, "R5 tick while disabled");
    rd_exp(A_PULSE, 7, "R5 pulse while disabled");
  endtask

  task automatic t_enable_count();
    wr(A_CTRL, 32'h1, "R3 enable");
    rd_exp(A_PULSE, 0, "R3 pulse cleared");
    rd_exp(A_TICK, 0, "R3 tick cleared");
    rd_exp(A_SNAP, 0, "R3 snap cleared");
    ticks(5);
    rd_exp(A_TICK, 5, "R4 tick after 5");
    rd_exp(A_SNAP, 5, "R7 snap after 5");
    ticks(7);
    rd_exp(A_TICK, 0, "R4 tick wraps at 12");
    rd_exp(A_PULSE, 1, "R4 pulse after wrap");
    ticks(27);
    rd_exp(A_PULSE, 3, "R4 pulse after 39");
    rd_exp(A_TICK, 3, "R4 tick after 39");
    rd_exp(A_SNAP, 3, "R7 snap after 39");
  endtask

  task automatic t_reenable_disable();
    wr(A_CTRL, 32'h1, "R3 rewrite enable");
    rd_exp(A_TICK, 3, "R3 tick kept on rewrite");
    rd_exp(A_PULSE, 3, "R3 pulse kept on rewrite");
    wr(A_CTRL, 32'h0, "R5 disable");
    ticks(4);
    rd_exp(A_TICK, 3, "R5 tick held");
    rd_exp(A_PULSE, 3, "R5 pulse held");
    wr(A_CTRL, 32'h1, "R3 re-enable");
    rd_exp(A_TICK, 0, "R3 tick cleared again");
    rd_exp(A_PULSE, 0, "R3 pulse cleared again");
  endtask

  task automatic t_load();
    wr(A_TICK, 32'd9, "R6 load 9");
    rd_exp(A_TICK, 9, "R6 tick loaded");
    rd_exp(A_SNAP, 9, "R6 snap loaded");
    ticks(2);
    rd_exp(A_TICK, 11, "R4 tick 11");
    ticks(1);
    rd_exp(A_TICK, 0, "R4 wrap from loaded");
    rd_exp(A_PULSE, 1, "R4 pulse from loaded");
    wr(A_TICK, 32'd13, "R6 load 13");
    ticks(1);
    rd_exp(A_TICK, 0, "R4 wrap beyond period");
    rd_exp(A_PULSE, 2, "R4 pulse beyond period");
  endtask

  task automatic t_snap_write();
    ticks(4);
    err_exp(1'b1, A_SNAP, "R8 snap write error");
    rd_exp(A_SNAP, 4, "R8 snap unchanged");
    rd_exp(A_TICK, 4, "R8 tick unchanged");
  endtask

  task automatic t_unmapped();
    err_exp(1'b0, 6'h10, "R9 read 0x10");
    err_exp(1'b0, 6'h20, "R9 read 0x20");
    err_exp(1'b0, 6'h2C, "R9 read 0x2C");
    err_exp(1'b0, 6'h01, "R9 read misaligned");
    err_exp(1'b1, 6'h14, "R9 write 0x14");
    err_exp(1'b1, 6'h0D, "R9 write misaligned tick");
    err_exp(1'b1, 6'h05, "R9 write misaligned pulse");
    rd_exp(A_TICK, 4, "R9 tick unchanged");
    rd_exp(A_PULSE, 2, "R9 pulse unchanged");
    rd_exp(A_CTRL, 1, "R9 ctrl unchanged");
  endtask

  task automatic t_collide();
    logic [31:0] rd; bit ak, er;
    access(1'b1, A_TICK, 32'd2, 1'b1, rd, ak, er);
    rd_exp(A_TICK, 2, "R11 tick write beats strobe");
    access(1'b1, A_PULSE, 32'd50, 1'b1, rd, ak, er);
    rd_exp(A_PULSE, 50, "R11 pulse write");
    rd_exp(A_TICK, 2, "R11 strobe dropped on pulse write");
    access(1'b0, A_TICK, '0, 1'b1, rd, ak, er);
    check(ak && rd == 2, "R2 read sees pre-edge value", rd, 2);
    rd_exp(A_TICK, 3, "R2 strobe with read counts");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_storage();
    t_disabled();
    t_enable_count();
    t_reenable_disable();
    t_load();
    t_snap_write();
    t_unmapped();
    t_collide();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end
endmodule